// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 32768 eight-bit words. It accepts one read or one write at a time over a request/ready handshake. It then produces the address, the active-low chip select, output enable and write enable, and the controller side of the shared data bus. Each of these strobes holds for a number of clock cycles that is derived from nanosecond limits. The bus appears as a data-out word, a data-in word and a separate enable for the external tristate driver.

Two timing sets are built in, a 55 ns grade and a 70 ns grade, and the `SPEED_NS` parameter selects one. `CLK_PERIOD_NS` gives the clock period. Every limit is turned into a cycle count by rounding up, with a floor of one cycle. The controller follows a fixed sequence of named states:

- **Read:** `ST_IDLE` to `ST_RD_ACCESS` on a read request, then `ST_RD_RELEASE` when the access count runs out, then back to `ST_IDLE`.
- **Write:** `ST_IDLE` to `ST_WR_TURN` on a write request, then `ST_WR_PULSE`, then `ST_WR_HOLD`, then `ST_WR_RECOVER`, then back to `ST_IDLE`.

Each state leaves when its phase timer expires. A request is taken only in `ST_IDLE`, where ready is high.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and right after a synchronous active-high reset, chip select, output enable and write enable are high, the data driver enable is low, ready is high and read-data-valid is low.
- R2: Ready falls in the cycle after a request is taken and stays low until the whole cycle is done. A request raised while ready is low is ignored and does not reach the memory.
- R3: A read holds chip select and output enable low with write enable high for ceil(max(access, OE-to-data)/clock) cycles, which is 7 at 70 ns and 10 ns. The address stays steady and equal to the requested one whenever chip select is low.
- R4: The read word is sampled at the end of the last access cycle. Read-data-valid is high for exactly one cycle, the first cycle after output enable rises, and the data output carries the addressed word.
- R5: A read keeps ready low for the access count plus max(ceil(release/clock), read cycle count minus access count), which is 10 cycles at 70 ns and 10 ns.
- R6: A write first lowers chip select with write enable and output enable high and the driver off for ceil(release/clock) cycles (3 at 70 ns). Write enable is low only while chip select is low.
- R7: Write enable stays low for ceil(max(pulse width, CS-to-end, address-to-end, data setup)/clock) cycles (6 at 70 ns). Output enable never goes low during a write.
- R8: The data driver enable rises in the same cycle that write enable falls. It stays on for the write pulse plus ceil(data hold/clock) cycles, with a floor of one (7 cycles in total), and the driven word equals the requested write data.
- R9: A write ends with chip select and write enable rising together. It is followed by hold and recovery phases, so ready stays low for turnaround + pulse + hold + max(write cycle count minus those three, 1) cycles (11 at 70 ns). The stored word reads back unchanged.
- R10: The data driver enable is never high while output enable is low. It is never high while the memory may still be driving the bus after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request strobe, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | High when a new request can be taken |
| host_rdata | output | DATA_W | Last word read |
| host_rvalid | output | 1 | One-cycle pulse when host_rdata is new |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the external data tristate driver |
| mem_dq_in | input | DATA_W | Data seen on the bus |

## Verification
The bench builds the controller with the 70 ns timing set and a 10 ns clock. This choice makes every strobe phase span several cycles: access 7, release 3, turnaround 3, write pulse 6 and hold 1. Miscounted phase lengths and off-by-one timer loads therefore show up as wrong cycle counts rather than collapsing to one cycle. The memory model keeps driving the bus for the release time after each read. Back-to-back read and write requests then expose any driver turn-on that comes before the bus is free. A full 15-bit top address shows whether the address path carries every bit.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RELEASE,
        ST_WR_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_RECOVER
    } ctrl_state_e;

    // Nanosecond limits of one speed grade.
    typedef struct packed {
        int unsigned rd_cycle;
        int unsigned rd_access;
        int unsigned oe_to_data;
        int unsigned bus_release;
        int unsigned wr_cycle;
        int unsigned wr_pulse;
        int unsigned cs_to_end;
        int unsigned addr_to_end;
        int unsigned data_setup;
        int unsigned data_hold;
    } grade_ns_t;

    function automatic grade_ns_t grade_fast();
        grade_ns_t g;
        g.rd_cycle    = 55;
        g.rd_access   = 55;
        g.oe_to_data  = 25;
        g.bus_release = 20;
        g.wr_cycle    = 55;
        g.wr_pulse    = 40;
        g.cs_to_end   = 45;
        g.addr_to_end = 45;
        g.data_setup  = 25;
        g.data_hold   = 0;
        return g;
    endfunction

    function automatic grade_ns_t grade_slow();
        grade_ns_t g;
        g.rd_cycle    = 70;
        g.rd_access   = 70;
        g.oe_to_data  = 35;
        g.bus_release = 25;
        g.wr_cycle    = 70;
        g.wr_pulse    = 50;
        g.cs_to_end   = 60;
        g.addr_to_end = 60;
        g.data_setup  = 30;
        g.data_hold   = 0;
        return g;
    endfunction

    // Round up to whole clocks, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_lengths.sv
module sram_phase_lengths
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned SPEED_NS      = 55,
    parameter int unsigned CNT_W         = 4
) (
    output logic [CNT_W-1:0] rd_access_len,
    output logic [CNT_W-1:0] rd_release_len,
    output logic [CNT_W-1:0] wr_turn_len,
    output logic [CNT_W-1:0] wr_pulse_len,
    output logic [CNT_W-1:0] wr_hold_len,
    output logic [CNT_W-1:0] wr_recover_len
);

    localparam grade_ns_t TS = (SPEED_NS == 70) ? grade_slow() : grade_fast();

    localparam int unsigned RD_CYC   = ns_to_cyc(TS.rd_cycle, CLK_PERIOD_NS);
    localparam int unsigned RD_ACC   = max2(ns_to_cyc(TS.rd_access, CLK_PERIOD_NS),
                                            ns_to_cyc(TS.oe_to_data, CLK_PERIOD_NS));
    localparam int unsigned REL_CYC  = ns_to_cyc(TS.bus_release, CLK_PERIOD_NS);
    localparam int unsigned RD_FILL  = (RD_CYC > RD_ACC) ? (RD_CYC - RD_ACC) : 1;
    localparam int unsigned RD_REL   = max2(REL_CYC, RD_FILL);

    localparam int unsigned WR_CYC   = ns_to_cyc(TS.wr_cycle, CLK_PERIOD_NS);
    localparam int unsigned WR_TURN  = REL_CYC;
    localparam int unsigned WR_PULSE = max2(max2(ns_to_cyc(TS.wr_pulse, CLK_PERIOD_NS),
                                                 ns_to_cyc(TS.cs_to_end, CLK_PERIOD_NS)),
                                            max2(ns_to_cyc(TS.addr_to_end, CLK_PERIOD_NS),
                                                 ns_to_cyc(TS.data_setup, CLK_PERIOD_NS)));
    localparam int unsigned WR_HOLD  = ns_to_cyc(TS.data_hold, CLK_PERIOD_NS);
    localparam int unsigned WR_USED  = WR_TURN + WR_PULSE + WR_HOLD;
    localparam int unsigned WR_REC   = (WR_CYC > WR_USED) ? (WR_CYC - WR_USED) : 1;

    assign rd_access_len  = CNT_W'(RD_ACC);
    assign rd_release_len = CNT_W'(RD_REL);
    assign wr_turn_len    = CNT_W'(WR_TURN);
    assign wr_pulse_len   = CNT_W'(WR_PULSE);
    assign wr_hold_len    = CNT_W'(WR_HOLD);
    assign wr_recover_len = CNT_W'(WR_REC);

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_len - CNT_W'(1);
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            dq_out   <= '0;
            rdata    <= '0;
            rvalid   <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr <= host_addr;
                dq_out   <= host_wdata;
            end
            if (capture) begin
                rdata <= dq_in;
            end
            rvalid <= capture;
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 15,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned SPEED_NS      = 55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // Longest phase is bounded by twice the grade.
    localparam int unsigned MAX_CYC = (2 * SPEED_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 2);

    ctrl_state_e      state, state_nx;
    logic             load;
    logic [CNT_W-1:0] load_len;
    logic             expired;
    logic             accept;
    logic             capture;

    logic [CNT_W-1:0] rd_access_len, rd_release_len;
    logic [CNT_W-1:0] wr_turn_len, wr_pulse_len, wr_hold_len, wr_recover_len;

    sram_phase_lengths #(
        .CLK_PERIOD_NS (CLK_PERIOD_NS),
        .SPEED_NS      (SPEED_NS),
        .CNT_W         (CNT_W)
    ) u_lengths (
        .rd_access_len  (rd_access_len),
        .rd_release_len (rd_release_len),
        .wr_turn_len    (wr_turn_len),
        .wr_pulse_len   (wr_pulse_len),
        .wr_hold_len    (wr_hold_len),
        .wr_recover_len (wr_recover_len)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_len (load_len),
        .expired  (expired)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and phase timer load.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (host_req) begin
                    state_nx = host_we ? ST_WR_TURN : ST_RD_ACCESS;
                end
            end
            ST_RD_ACCESS:  if (expired) state_nx = ST_RD_RELEASE;
            ST_RD_RELEASE: if (expired) state_nx = ST_IDLE;
            ST_WR_TURN:    if (expired) state_nx = ST_WR_PULSE;
            ST_WR_PULSE:   if (expired) state_nx = ST_WR_HOLD;
            ST_WR_HOLD:    if (expired) state_nx = ST_WR_RECOVER;
            ST_WR_RECOVER: if (expired) state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase

        load     = (state_nx != state);
        load_len = CNT_W'(1);
        unique case (state_nx)
            ST_IDLE:       load_len = CNT_W'(1);
            ST_RD_ACCESS:  load_len = rd_access_len;
            ST_RD_RELEASE: load_len = rd_release_len;
            ST_WR_TURN:    load_len = wr_turn_len;
            ST_WR_PULSE:   load_len = wr_pulse_len;
            ST_WR_HOLD:    load_len = wr_hold_len;
            ST_WR_RECOVER: load_len = wr_recover_len;
            default:       load_len = CNT_W'(1);
        endcase
    end

    assign accept     = (state == ST_IDLE) && host_req;
    assign capture    = (state == ST_RD_ACCESS) && expired;
    assign host_ready = (state == ST_IDLE);

    // Registered strobes, decoded from the state being entered.
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_cs_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= !(state_nx inside {ST_RD_ACCESS, ST_WR_TURN, ST_WR_PULSE});
            mem_oe_n  <= !(state_nx == ST_RD_ACCESS);
            mem_we_n  <= !(state_nx == ST_WR_PULSE);
            mem_dq_oe <= (state_nx inside {ST_WR_PULSE, ST_WR_HOLD});
        end
    end

    sram_data_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .capture    (capture),
        .dq_in      (mem_dq_in),
        .mem_addr   (mem_addr),
        .dq_out     (mem_dq_out),
        .rdata      (host_rdata),
        .rvalid     (host_rvalid)
    );

endmodule

// File: rtl/sram_strobe_ctrl_checks.sv
module sram_strobe_ctrl_checks #(
    parameter int unsigned ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              host_req,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ready) |=> !host_ready);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    p_rvalid_single_r4: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid);

    p_rvalid_after_oe_r4: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> !$past(mem_oe_n));

    p_we_inside_cs_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    p_drive_with_we_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $rose(mem_dq_oe));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (mem_cs_n && mem_we_n && !mem_dq_oe));

    p_no_drive_in_read_r10: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_checks #(
    .ADDR_W (ADDR_W)
) u_checks (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;

    localparam int CLK_NS = 10;
    localparam int GRADE  = 70;

    function automatic int up_cyc(int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    // Expected counts for the 70 ns set at this clock.
    localparam int E_ACC      = up_cyc(70);
    localparam int E_TAIL     = up_cyc(25);
    localparam int E_RD_BUSY  = E_ACC + E_TAIL;
    localparam int E_TURN     = up_cyc(25);
    localparam int E_PULSE    = up_cyc(60);
    localparam int E_HOLD     = 1;
    localparam int E_WR_BUSY  = E_TURN + E_PULSE + E_HOLD + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        hwe = 1'b0;
    logic [14:0] haddr = '0;
    logic [7:0]  hwd = '0;
    logic        ready, rvalid, cs_n, oe_n, we_n, dq_oe;
    logic [7:0]  rdata, dq_out, dq_in;
    logic [14:0] maddr;

    int total = 0;
    int fails = 0;
    int contention = 0;
    bit done = 0;

    always #(CLK_NS / 2) clk = ~clk;

    sram_strobe_ctrl #(
        .ADDR_W        (15),
        .DATA_W        (8),
        .CLK_PERIOD_NS (CLK_NS),
        .SPEED_NS      (GRADE)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .host_req    (req),
        .host_we     (hwe),
        .host_addr   (haddr),
        .host_wdata  (hwd),
        .host_ready  (ready),
        .host_rdata  (rdata),
        .host_rvalid (rvalid),
        .mem_addr    (maddr),
        .mem_cs_n    (cs_n),
        .mem_oe_n    (oe_n),
        .mem_we_n    (we_n),
        .mem_dq_out  (dq_out),
        .mem_dq_oe   (dq_oe),
        .mem_dq_in   (dq_in)
    );

    // Memory model: low address byte selects one of 256 words.
    logic [7:0] mem [256];
    logic [2:0] tail;
    logic       pend;
    logic [7:0] pend_a, pend_d;
    logic       read_mode, mem_drive;

    assign read_mode = !cs_n && !oe_n && we_n;
    assign mem_drive = read_mode || (tail != 3'd0);
    assign dq_in     = mem_drive ? mem[maddr[7:0]] : 8'hEE;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
            tail <= 3'd0;
            pend <= 1'b0;
        end else begin
            if (read_mode) tail <= 3'(E_TAIL);
            else if (tail != 3'd0) tail <= tail - 3'd1;
            if (!cs_n && !we_n) begin
                pend   <= 1'b1;
                pend_a <= maddr[7:0];
                pend_d <= dq_oe ? dq_out : 8'hEE;
            end else if (pend) begin
                mem[pend_a] <= pend_d;
                pend <= 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && mem_drive && dq_oe) contention++;
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct {
        int busy;
        int oe_run;
        int we_run;
        int turn;
        int dq_run;
        int rv;
        int rv_idx;
        int addr_err;
        int data_err;
        logic [7:0] rd;
    } op_res_t;

    task automatic run_op(input logic we, input logic [14:0] a, input logic [7:0] d,
                          input bit intrude, output op_res_t r);
        int idx;
        r = '{default: 0};
        @(negedge clk);
        req = 1'b1; hwe = we; haddr = a; hwd = d;
        @(negedge clk);
        req = 1'b0;
        idx = 0;
        while (!ready) begin
            if (!cs_n && !oe_n && we_n) r.oe_run++;
            if (!we_n) r.we_run++;
            if (!cs_n && we_n && oe_n) r.turn++;
            if (dq_oe) begin
                r.dq_run++;
                if (dq_out != d) r.data_err++;
            end
            if (!cs_n && maddr != a) r.addr_err++;
            if (rvalid) begin
                r.rv++;
                r.rv_idx = idx;
                r.rd = rdata;
            end
            if (intrude && idx == 2) begin
                req = 1'b1; hwe = 1'b1; haddr = 15'h0040; hwd = 8'hFF;
            end
            if (intrude && idx == 4) req = 1'b0;
            idx++;
            @(negedge clk);
        end
        r.busy = idx;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 cs_n in reset", cs_n, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cs_n", cs_n, 1);
        check("R1 oe_n", oe_n, 1);
        check("R1 we_n", we_n, 1);
        check("R1 dq_oe", dq_oe, 0);
        check("R1 ready", ready, 1);
        check("R1 rvalid", rvalid, 0);
    endtask

    task automatic test_read_preload();
        op_res_t r;
        run_op(1'b0, 15'h0012, 8'h00, 0, r);
        check("R3 read strobe cycles", r.oe_run, E_ACC);
        check("R3 read address", r.addr_err, 0);
        check("R4 read data", r.rd, 8'h12 ^ 8'h5A);
        check("R4 rvalid count", r.rv, 1);
        check("R4 rvalid position", r.rv_idx, E_ACC);
        check("R5 read busy", r.busy, E_RD_BUSY);
        check("R10 no drive on read", r.dq_run, 0);
    endtask

    task automatic test_write_readback();
        op_res_t w, r;
        run_op(1'b1, 15'h7F34, 8'hC3, 0, w);
        check("R6 turnaround", w.turn, E_TURN);
        check("R7 write pulse", w.we_run, E_PULSE);
        check("R7 oe during write", w.oe_run, 0);
        check("R8 driver cycles", w.dq_run, E_PULSE + E_HOLD);
        check("R8 driven data", w.data_err, 0);
        check("R9 write busy", w.busy, E_WR_BUSY);
        run_op(1'b0, 15'h7F34, 8'h00, 0, r);
        check("R9 readback", r.rd, 8'hC3);
    endtask

    task automatic test_ignored_request();
        op_res_t r, q;
        run_op(1'b0, 15'h0051, 8'h00, 1, r);
        check("R2 busy with intruder", r.busy, E_RD_BUSY);
        check("R2 no write strobe", r.we_run, 0);
        check("R4 read under intruder", r.rd, 8'h51 ^ 8'h5A);
        run_op(1'b0, 15'h0040, 8'h00, 0, q);
        check("R2 intruder write dropped", q.rd, 8'h40 ^ 8'h5A);
    endtask

    task automatic test_edge_addresses();
        op_res_t w, r;
        run_op(1'b1, 15'h7FFF, 8'hA5, 0, w);
        check("R3 top address write", w.addr_err, 0);
        run_op(1'b0, 15'h7FFF, 8'h00, 0, r);
        check("R3 top address read", r.addr_err, 0);
        check("R9 top readback", r.rd, 8'hA5);
        run_op(1'b1, 15'h0000, 8'h3C, 0, w);
        run_op(1'b0, 15'h0000, 8'h00, 0, r);
        check("R9 zero readback", r.rd, 8'h3C);
    endtask

    task automatic test_back_to_back();
        op_res_t a, b, c;
        run_op(1'b0, 15'h0077, 8'h00, 0, a);
        run_op(1'b1, 15'h0078, 8'h96, 0, b);
        run_op(1'b0, 15'h0078, 8'h00, 0, c);
        check("R9 back to back readback", c.rd, 8'h96);
        check("R10 bus contention cycles", contention, 0);
    endtask

    initial begin
        test_reset();
        test_read_preload();
        test_write_readback();
        test_ignored_request();
        test_edge_addresses();
        test_back_to_back();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule